// File: doc/BRIEF.md
# Byte Matrix Transpose Engine

The engine swaps rows and columns of a 4x4 matrix of bytes kept in memory as four consecutive 32-bit words, one word per row. It reads the four row words, rearranges their bytes with eight two-operand lane permutations, and writes four column words to a destination area. Each permutation result goes to its own register, so the loaded row words stay intact until the run ends.

A client places source and destination base addresses on the inputs and raises `start` for one cycle. The engine then works without further help and raises `done` for one cycle when the last column word has been written. The memory side has two word lanes. Each lane carries one reference per cycle, and a read returns its data one cycle after the request.

A full transpose takes eight memory references and eight permutations. It does not use a byte-by-byte load/store loop.

Top module: `bxp_engine`

## Requirements
- R1: While reset is asserted and afterwards until a start is accepted, no lane requests memory and `done` is low.
- R2: A start is accepted when `start` is high at a clock edge while the engine is idle. Call the cycle after that edge cycle 1. In cycle 1 both lanes read: lane 0 at source base +0 and lane 1 at source base +4. In cycle 2 both lanes read: lane 0 at +8 and lane 1 at +12.
- R3: Byte (r,c) is bits [31-8c : 24-8c] of the word at source base + 4r. In cycle 6 both lanes write: lane 0 writes column 0 at destination base +0 and lane 1 writes column 1 at +4. In cycle 7 lane 0 writes column 2 at +8 and lane 1 writes column 3 at +12. Column word c holds source byte (r,c) at bits [31-8r : 24-8r].
- R4: `done` is high in cycle 8 only, which is the cycle after the final store. It is a one-cycle pulse.
- R5: No lane requests memory in any cycle other than cycles 1, 2, 6 and 7. A transpose therefore makes exactly eight word references, and at most two in any cycle.
- R6: A start seen while a transpose is in progress is ignored. It adds no memory reference and does not move `done`.
- R7: The base addresses are sampled only at the accepting edge. Changing them during a run has no effect on that run's addresses.
- R8: The engine is idle again in cycle 8, so a start held high through `done` begins the next transpose at once.
- R9: All loads come before any store, so a transpose with destination equal to source gives the correct in-place result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a transpose |
| src_base | input | ADDR_W | Byte address of source row 0 |
| dst_base | input | ADDR_W | Byte address of destination column 0 |
| mem_req | output | 2 | Per-lane memory request |
| mem_we | output | 2 | Per-lane write enable (0 = read) |
| mem_addr | output | 2 x ADDR_W | Per-lane byte address |
| mem_wdata | output | 2 x 32 | Per-lane write data |
| mem_rdata | input | 2 x 32 | Per-lane read data, valid one cycle after a read request |
| done | output | 1 | One-cycle completion pulse |

## Verification
The permutation network is tested with several kinds of matrix. A ramp of sixteen distinct byte values exposes any byte that lands in the wrong row or column. A matrix with a single nonzero byte tells a lost byte apart from a duplicated one. Random matrices at assorted addresses cover everything else. An in-place run tests load/store ordering. A run where start is pulsed a second time and the bases are changed mid-flight tests that the engine ignores them. Holding start high through done tests back-to-back acceptance.

// File: rtl/bxp_pkg.sv
package bxp_pkg;

    localparam int DIM        = 4;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = DIM * BYTE_W;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int LANES      = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LD01,
        PH_LD23,
        PH_CAP,
        PH_MRG,
        PH_PK01,
        PH_ST01,
        PH_ST23
    } phase_e;

    typedef enum logic [1:0] {
        PERM_MRG_HI,
        PERM_MRG_LO,
        PERM_PAK_HI,
        PERM_PAK_LO
    } perm_e;

    // Byte lanes are numbered from the most significant end.
    function automatic word_t permute(perm_e op, word_t a, word_t b);
        word_t y;
        y = '0;
        case (op)
            // Interleave the upper two bytes of each operand.
            PERM_MRG_HI: y = {a[4*BYTE_W-1 -: BYTE_W], b[4*BYTE_W-1 -: BYTE_W],
                              a[3*BYTE_W-1 -: BYTE_W], b[3*BYTE_W-1 -: BYTE_W]};
            // Interleave the lower two bytes of each operand.
            PERM_MRG_LO: y = {a[2*BYTE_W-1 -: BYTE_W], b[2*BYTE_W-1 -: BYTE_W],
                              a[BYTE_W-1 -: BYTE_W],   b[BYTE_W-1 -: BYTE_W]};
            // Join the upper halves.
            PERM_PAK_HI: y = {a[WORD_W-1 -: WORD_W/2], b[WORD_W-1 -: WORD_W/2]};
            // Join the lower halves.
            PERM_PAK_LO: y = {a[WORD_W/2-1:0], b[WORD_W/2-1:0]};
            default:     y = '0;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/bxp_perm.sv
module bxp_perm
    import bxp_pkg::*;
#(
    parameter perm_e OP = PERM_MRG_HI
) (
    input  word_t a,
    input  word_t b,
    output word_t y
);

    assign y = permute(OP, a, b);

endmodule

// File: rtl/bxp_seq.sv
module bxp_seq
    import bxp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase,
    output logic   accept,
    output logic   done
);

    typedef struct packed {
        phase_e phase;
        logic   done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        accept   = start && (s_q.phase == PH_IDLE);
        s_d.done = (s_q.phase == PH_ST23);
        case (s_q.phase)
            PH_IDLE: if (accept) s_d.phase = PH_LD01;
            PH_LD01: s_d.phase = PH_LD23;
            PH_LD23: s_d.phase = PH_CAP;
            PH_CAP:  s_d.phase = PH_MRG;
            PH_MRG:  s_d.phase = PH_PK01;
            PH_PK01: s_d.phase = PH_ST01;
            PH_ST01: s_d.phase = PH_ST23;
            PH_ST23: s_d.phase = PH_IDLE;
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase = s_q.phase;
    assign done  = s_q.done;

endmodule

// File: rtl/bxp_port.sv
module bxp_port
    import bxp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  phase_e                        phase,
    input  logic [ADDR_W-1:0]             src,
    input  logic [ADDR_W-1:0]             dst,
    input  word_t [DIM-1:0]               outw,
    output logic [LANES-1:0]              mem_req,
    output logic [LANES-1:0]              mem_we,
    output logic [LANES-1:0][ADDR_W-1:0]  mem_addr,
    output word_t [LANES-1:0]             mem_wdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [ADDR_W-1:0] OFS_LO = ADDR_W'(WORD_BYTES * l);
        localparam logic [ADDR_W-1:0] OFS_HI = ADDR_W'(WORD_BYTES * (LANES + l));

        logic              rq;
        logic              wr;
        logic [ADDR_W-1:0] ad;
        word_t             wd;

        always_comb begin
            rq = 1'b0;
            wr = 1'b0;
            ad = '0;
            wd = '0;
            case (phase)
                PH_LD01: begin rq = 1'b1; ad = src + OFS_LO; end
                PH_LD23: begin rq = 1'b1; ad = src + OFS_HI; end
                PH_ST01: begin rq = 1'b1; wr = 1'b1; ad = dst + OFS_LO; wd = outw[l]; end
                PH_ST23: begin rq = 1'b1; wr = 1'b1; ad = dst + OFS_HI; wd = outw[LANES+l]; end
                default: ;
            endcase
        end

        assign mem_req[l]   = rq;
        assign mem_we[l]    = wr;
        assign mem_addr[l]  = ad;
        assign mem_wdata[l] = wd;
    end

endmodule

// File: rtl/bxp_engine.sv
module bxp_engine
    import bxp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [ADDR_W-1:0]            src_base,
    input  logic [ADDR_W-1:0]            dst_base,
    output logic [1:0]                   mem_req,
    output logic [1:0]                   mem_we,
    output logic [1:0][ADDR_W-1:0]       mem_addr,
    output logic [1:0][WORD_W-1:0]       mem_wdata,
    input  logic [1:0][WORD_W-1:0]       mem_rdata,
    output logic                         done
);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        word_t [DIM-1:0]   w;   // loaded rows, kept for the whole run
        word_t [DIM-1:0]   t;   // merge results
        word_t [DIM-1:0]   o;   // column words
    } regs_t;

    regs_t  r_d, r_q;
    phase_e phase;
    logic   accept;
    word_t  t_calc [DIM];
    word_t  o_calc [DIM];

    bxp_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .phase  (phase),
        .accept (accept),
        .done   (done)
    );

    // Eight permutation units: four merges on row pairs, four packs on merge pairs.
    for (genvar g = 0; g < DIM; g++) begin : g_perm
        localparam int PAIR = g % 2;
        localparam int HALF = g / 2;

        bxp_perm #(.OP(perm_e'(g < 2 ? PERM_MRG_HI : PERM_MRG_LO))) u_merge (
            .a (r_q.w[2*PAIR]),
            .b (r_q.w[2*PAIR+1]),
            .y (t_calc[g])
        );

        bxp_perm #(.OP(perm_e'(PAIR == 0 ? PERM_PAK_HI : PERM_PAK_LO))) u_pack (
            .a (r_q.t[2*HALF]),
            .b (r_q.t[2*HALF+1]),
            .y (o_calc[g])
        );
    end

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.src = src_base;
            r_d.dst = dst_base;
        end
        case (phase)
            PH_LD23: begin
                r_d.w[0] = mem_rdata[0];
                r_d.w[1] = mem_rdata[1];
            end
            PH_CAP: begin
                r_d.w[2] = mem_rdata[0];
                r_d.w[3] = mem_rdata[1];
                r_d.t[0] = t_calc[0];
                r_d.t[2] = t_calc[2];
            end
            PH_MRG: begin
                r_d.t[1] = t_calc[1];
                r_d.t[3] = t_calc[3];
            end
            PH_PK01: begin
                r_d.o[0] = o_calc[0];
                r_d.o[1] = o_calc[1];
            end
            PH_ST01: begin
                r_d.o[2] = o_calc[2];
                r_d.o[3] = o_calc[3];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    bxp_port #(.ADDR_W(ADDR_W)) u_port (
        .phase     (phase),
        .src       (r_q.src),
        .dst       (r_q.dst),
        .outw      (r_q.o),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/bxp_engine_chk.sv
module bxp_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             mem_req,
    input logic [1:0]             mem_we,
    input logic [1:0][ADDR_W-1:0] mem_addr,
    input logic                   done
);

    // R5
    paired_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req != 2'b00) |-> (mem_req == 2'b11 && mem_we[0] == mem_we[1]));

    // R2
    load_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req == 2'b11 && mem_we == 2'b00) |-> (mem_addr[1] == mem_addr[0] + ADDR_W'(4)));

    // R3
    store_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req == 2'b11 && mem_we == 2'b11) |-> (mem_addr[1] == mem_addr[0] + ADDR_W'(4)));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req == 2'b11 && mem_we == 2'b11));

    // R5
    quiet_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_req == 2'b00));

endmodule

bind bxp_engine bxp_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .done     (done)
);

// File: tb/bxp_engine_tb.sv
module bxp_engine_tb;

    localparam int AW = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [AW-1:0]       src_base = '0;
    logic [AW-1:0]       dst_base = '0;
    logic [1:0]          mem_req;
    logic [1:0]          mem_we;
    logic [1:0][AW-1:0]  mem_addr;
    logic [1:0][31:0]    mem_wdata;
    logic [1:0][31:0]    mem_rdata;
    logic                done;

    always #5 clk = ~clk;

    bxp_engine #(.ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .src_base  (src_base),
        .dst_base  (dst_base),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .done      (done)
    );

    // Word memory with one-cycle read latency.
    logic [31:0] mem [0:1023];
    always @(posedge clk) begin
        for (int l = 0; l < 2; l++) begin
            if (mem_req[l]) begin
                if (mem_we[l]) mem[mem_addr[l][11:2]] <= mem_wdata[l];
                else           mem_rdata[l] <= mem[mem_addr[l][11:2]];
            end
        end
    end

    int errors = 0;
    int checks = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: phase counter, latched bases, expected columns.
    int            ph = 0;
    logic [AW-1:0] m_src, m_dst;
    logic [31:0]   exp_col [4];

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1 reset quiet", {62'd0, |mem_req, done}, 64'd0);
        end else begin
            case (ph)
                1: begin
                    chk("R2 load1 kind", {mem_req, mem_we}, 64'b1100);
                    chk("R2 load1 addr0", mem_addr[0], m_src);
                    chk("R2 load1 addr1", mem_addr[1], m_src + 4);
                end
                2: begin
                    chk("R2 load2 kind", {mem_req, mem_we}, 64'b1100);
                    chk("R2 load2 addr0", mem_addr[0], m_src + 8);
                    chk("R2 load2 addr1", mem_addr[1], m_src + 12);
                end
                6: begin
                    chk("R3 store1 kind", {mem_req, mem_we}, 64'b1111);
                    chk("R3 store1 addr0", mem_addr[0], m_dst);
                    chk("R3 store1 addr1", mem_addr[1], m_dst + 4);
                    chk("R3 col0", mem_wdata[0], exp_col[0]);
                    chk("R3 col1", mem_wdata[1], exp_col[1]);
                end
                7: begin
                    chk("R3 store2 kind", {mem_req, mem_we}, 64'b1111);
                    chk("R3 store2 addr0", mem_addr[0], m_dst + 8);
                    chk("R3 store2 addr1", mem_addr[1], m_dst + 12);
                    chk("R3 col2", mem_wdata[0], exp_col[2]);
                    chk("R3 col3", mem_wdata[1], exp_col[3]);
                end
                default: chk("R5 no reference", mem_req, 64'd0);
            endcase
            chk("R4 done timing", done, (ph == 8) ? 64'd1 : 64'd0);

            if ((ph == 0 || ph == 8) && start) begin
                ph    = 1;
                m_src = src_base;
                m_dst = dst_base;
                for (int c = 0; c < 4; c++)
                    for (int r = 0; r < 4; r++)
                        exp_col[c][31-8*r -: 8] = mem[int'(m_src[11:2]) + r][31-8*c -: 8];
            end else if (ph >= 1 && ph <= 7) begin
                ph = ph + 1;
            end else begin
                ph = 0;
            end
        end
    end

    task automatic fill(input logic [AW-1:0] base, input logic [31:0] a, b, c, d);
        mem[int'(base[11:2]) + 0] = a;
        mem[int'(base[11:2]) + 1] = b;
        mem[int'(base[11:2]) + 2] = c;
        mem[int'(base[11:2]) + 3] = d;
    endtask

    task automatic snap(input logic [AW-1:0] base, output logic [31:0] s [4]);
        for (int r = 0; r < 4; r++) s[r] = mem[int'(base[11:2]) + r];
    endtask

    task automatic verify(input string tag, input logic [AW-1:0] d, input logic [31:0] s [4]);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                chk(tag, mem[int'(d[11:2]) + c][31-8*r -: 8], s[r][31-8*c -: 8]);
    endtask

    task automatic go(input logic [AW-1:0] s, input logic [AW-1:0] d);
        @(posedge clk); #1;
        start = 1'b1; src_base = s; dst_base = d;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (9) @(posedge clk);
    endtask

    task automatic run(input string tag, input logic [AW-1:0] s, input logic [AW-1:0] d);
        logic [31:0] sv [4];
        snap(s, sv);
        go(s, d);
        #1;
        verify(tag, d, sv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] sa [4];
        logic [31:0] sb [4];
        logic [31:0] keep [4];
        for (int i = 0; i < 1024; i++) mem[i] = $urandom;

        // R1: reset period
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R3: ramp of distinct bytes
        fill(16'h0000, 32'h00010203, 32'h04050607, 32'h08090a0b, 32'h0c0d0e0f);
        run("R3 ramp", 16'h0000, 16'h0100);

        // R3: single marked byte
        fill(16'h0040, 32'h0, 32'h0, 32'h0000a500, 32'h0);
        run("R3 single byte", 16'h0040, 16'h0140);

        // R3: random matrices at assorted bases
        run("R3 random a", 16'h0200, 16'h0300);
        run("R3 random b", 16'h0350, 16'h0220);
        run("R3 random c", 16'h0abc & 16'hfffc, 16'h0e00);

        // R9: in place
        run("R9 in place", 16'h0500, 16'h0500);

        // R6, R7: second start and base changes mid-run
        snap(16'h0600, sa);
        snap(16'h0700, keep);
        @(posedge clk); #1;
        start = 1'b1; src_base = 16'h0600; dst_base = 16'h0680;
        @(posedge clk); #1;
        start = 1'b0; src_base = 16'h0610; dst_base = 16'h0700;
        repeat (2) @(posedge clk); #1;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (8) @(posedge clk); #1;
        verify("R7 bases held", 16'h0680, sa);
        for (int r = 0; r < 4; r++)
            chk("R6 ignored start", mem[int'(16'h0700 >> 2) + r], keep[r]);

        // R8: start held through done
        snap(16'h0800, sa);
        snap(16'h0900, sb);
        @(posedge clk); #1;
        start = 1'b1; src_base = 16'h0800; dst_base = 16'h0880;
        @(posedge clk); #1;
        src_base = 16'h0900; dst_base = 16'h0980;
        repeat (8) @(posedge clk); #1;
        start = 1'b0;
        repeat (10) @(posedge clk); #1;
        verify("R8 first run", 16'h0880, sa);
        verify("R8 second run", 16'h0980, sb);

        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule